// File: doc/BRIEF.md
# Armed Single-Pulse Timer

This block emits exactly one timed pulse for every arming. Software arms it and loads a period and a delay. The first rising edge seen on an external trigger line then starts a counter. The output stays low for the delay and then high until the counter meets the period. The trigger line may keep toggling quickly the whole time. Edges that arrive while the pulse runs, or after it has ended, have no effect until software arms the block again.

The period lives in two registers, an active copy and a shadow copy. With shadowing switched on, a write lands only in the shadow. The shadow moves into the active copy at the update event, which is either the end of a pulse or an accepted arm strobe. If software preloads zero into the shadow, the pulse that follows installs a zero period when it ends. A zero period holds the counter stopped, so the block disables itself with no interrupt or memory transfer. To run again, software writes a non-zero period and arms.

Top module: `oneshot_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pulse_out` and `busy` are low. Both period copies reset to zero.
- R2: The trigger passes through a two-flop synchronizer and an edge detector. With D = `delay_val`, a rising edge driven on `trig_in` just after clock edge c makes `pulse_out` rise after clock edge c+3+D.
- R3: With N the active period, `pulse_out` stays high for N−D cycles when D < N. When D ≥ N the counter still runs, but `pulse_out` never rises.
- R4: Once counting has started, further trigger edges neither restart the count nor lengthen the pulse.
- R5: After a pulse, trigger edges start nothing until a new `arm` strobe is accepted. An `arm` strobe given while a pulse is running is ignored.
- R6: When `shadow_en`=1, `per_wr` writes only the shadow copy. The shadow is copied into the active period at the end of a pulse and on an accepted `arm`. A pulse already running keeps its period.
- R7: When `shadow_en`=0, `per_wr` updates the active period at once, and `arm` leaves the period unchanged.
- R8: While the period in force is zero, no trigger starts a pulse, even when the block is armed.
- R9: Writing zero to the shadow after arming makes the block disable itself at the end of the pulse. A later `arm` alone cannot restart it. Writing a non-zero period and then arming does restart it.
- R10: A trigger edge detected in the same cycle as an accepted `arm` strobe starts the pulse, with the timing of R2.
- R11: `busy` is high while a pulse runs, or while the block is armed with a non-zero period. It is low once the pulse has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous external trigger |
| arm | input | 1 | One-cycle strobe that enables triggering |
| per_wr | input | 1 | Period write strobe |
| per_data | input | CNT_W | Period value written by `per_wr` |
| shadow_en | input | 1 | 1: period writes are deferred to the update event |
| delay_val | input | CNT_W | Count at which the output goes high |
| pulse_out | output | 1 | The single output pulse |
| busy | output | 1 | Armed-or-pulsing status |

## Verification
The bench builds the block with an 8-bit counter, two synchronizer stages and the shadow variant present. Periods and delays of a few cycles therefore keep each pulse short, and several arm/trigger rounds fit in a brief run. Because the shadow register exists, the bench can test the deferred path and the immediate-write path by flipping `shadow_en` at run time. This covers the self-disable sequence, the re-arm after it, a period change during a running pulse, and the same-cycle arm and trigger case.

// File: rtl/ost_pkg.sv
package ost_pkg;
   localparam int unsigned OST_MIN_SYNC = 2;
   localparam int unsigned OST_MIN_CNT_W = 2;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;
endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise
);
   localparam int unsigned TAPS = STAGES + 1;

   logic [TAPS-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[TAPS-2:0], din};
   end

   // edge taken between the last synchronizer flop and one history flop
   assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ost_period_regs.sv
module ost_period_regs #(
   parameter int unsigned CNT_W      = 16,
   parameter bit          HAS_SHADOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             shadow_en,
   input  logic             load,
   output logic [CNT_W-1:0] act_o,
   output logic [CNT_W-1:0] shd_o
);
   generate
      if (HAS_SHADOW) begin : g_shadow
         logic [CNT_W-1:0] act_q;
         logic [CNT_W-1:0] shd_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               act_q <= '0;
               shd_q <= '0;
            end else begin
               if (wr_en) shd_q <= wr_data;
               if (wr_en && !shadow_en)    act_q <= wr_data;
               else if (load && shadow_en) act_q <= shd_q;
            end
         end
         assign act_o = act_q;
         assign shd_o = shd_q;
      end else begin : g_direct
         logic [CNT_W-1:0] act_q;
         logic             unused_ctl;
         always_ff @(posedge clk) begin
            if (rst)        act_q <= '0;
            else if (wr_en) act_q <= wr_data;
         end
         assign unused_ctl = shadow_en | load;
         assign act_o = act_q;
         assign shd_o = act_q;
      end
   endgenerate
endmodule

// File: rtl/ost_pulse_core.sv
module ost_pulse_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rise,
   input  logic             arm_ok,
   input  logic [CNT_W-1:0] eff_period,
   input  logic [CNT_W-1:0] act_period,
   input  logic [CNT_W-1:0] delay,
   output logic             running,
   output logic             armed,
   output logic [CNT_W-1:0] cnt,
   output logic             pulse,
   output logic             end_evt
);
   import ost_pkg::*;

   phase_e ph;
   logic   start;

   assign start   = (ph == PH_IDLE) && rise && (armed || arm_ok) && (eff_period != '0);
   assign end_evt = (ph == PH_RUN) && (cnt >= act_period);

   always_ff @(posedge clk) begin
      if (rst) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         armed <= 1'b0;
      end else if (start) begin
         ph    <= PH_RUN;
         cnt   <= CNT_W'(1);
         armed <= 1'b0;
      end else begin
         if (end_evt) begin
            ph  <= PH_IDLE;
            cnt <= '0;
         end else if (ph == PH_RUN) begin
            cnt <= cnt + 1'b1;
         end
         if (arm_ok) armed <= 1'b1;
      end
   end

   assign running = (ph == PH_RUN);
   assign pulse   = running && (cnt > delay);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_SHADOW  = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             trig_in,
   input  logic             arm,
   input  logic             per_wr,
   input  logic [CNT_W-1:0] per_data,
   input  logic             shadow_en,
   input  logic [CNT_W-1:0] delay_val,
   output logic             pulse_out,
   output logic             busy
);
   import ost_pkg::*;

   generate
      if (SYNC_STAGES < OST_MIN_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES must be at least %0d", OST_MIN_SYNC);
      end
      if (CNT_W < OST_MIN_CNT_W) begin : g_bad_width
         $error("CNT_W must be at least %0d", OST_MIN_CNT_W);
      end
   endgenerate

   logic             rise;
   logic             running;
   logic             armed;
   logic             arm_ok;
   logic             end_evt;
   logic             shd_live;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] act_period;
   logic [CNT_W-1:0] shd_period;
   logic [CNT_W-1:0] eff_period;

   assign arm_ok   = arm && !running;
   assign shd_live = shadow_en && HAS_SHADOW;
   // an accepted arm installs the shadow in the same edge that may start the count
   assign eff_period = (arm_ok && shd_live) ? shd_period : act_period;

   ost_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (trig_in),
      .rise (rise)
   );

   ost_period_regs #(.CNT_W(CNT_W), .HAS_SHADOW(HAS_SHADOW)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (per_wr),
      .wr_data   (per_data),
      .shadow_en (shadow_en),
      .load      (end_evt || arm_ok),
      .act_o     (act_period),
      .shd_o     (shd_period)
   );

   ost_pulse_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst        (rst),
      .rise       (rise),
      .arm_ok     (arm_ok),
      .eff_period (eff_period),
      .act_period (act_period),
      .delay      (delay_val),
      .running    (running),
      .armed      (armed),
      .cnt        (cnt),
      .pulse      (pulse_out),
      .end_evt    (end_evt)
   );

   assign busy = running || (armed && (act_period != '0));
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             arm,
   input logic             shadow_en,
   input logic             pulse_out,
   input logic             busy,
   input logic             running,
   input logic             armed,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_period
);
   AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!pulse_out && !busy)); // R1
   AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (rst) pulse_out |-> busy); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) $fell(running) |-> !busy); // R11
   AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (running && $past(running)) |-> (cnt == $past(cnt) + 1'b1)); // R4
   AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
      $rose(running) |-> $past(armed || arm)); // R5
   AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
      ($past(act_period == '0) && !$past(running) && !$past(arm && shadow_en)) |-> !running); // R8
   AST_SHADOW_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (shadow_en && $past(shadow_en) && running && $past(running)) |-> $stable(act_period)); // R6
endmodule

bind oneshot_timer ost_checker #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .arm        (arm),
   .shadow_en  (shadow_en),
   .pulse_out  (pulse_out),
   .busy       (busy),
   .running    (running),
   .armed      (armed),
   .cnt        (cnt),
   .act_period (act_period)
);

// File: tb/oneshot_timer_test.sv
module oneshot_timer_test;
   localparam int unsigned CNT_W = 8;

   typedef struct {
      int    rise_at;
      int    width;
      string req;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             trig_in = 1'b0;
   logic             arm = 1'b0;
   logic             per_wr = 1'b0;
   logic [CNT_W-1:0] per_data = '0;
   logic             shadow_en = 1'b0;
   logic [CNT_W-1:0] delay_val = '0;
   logic             pulse_out;
   logic             busy;

   int   cyc = 0;
   int   nchk = 0;
   int   nerr = 0;
   int   pulses_seen = 0;
   bit   done = 1'b0;
   exp_t exp_q[$];

   oneshot_timer #(.CNT_W(CNT_W), .SYNC_STAGES(2), .HAS_SHADOW(1'b1)) uut (
      .clk       (clk),
      .rst       (rst),
      .trig_in   (trig_in),
      .arm       (arm),
      .per_wr    (per_wr),
      .per_data  (per_data),
      .shadow_en (shadow_en),
      .delay_val (delay_val),
      .pulse_out (pulse_out),
      .busy      (busy)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_period(input int v);
      per_wr = 1'b1;
      per_data = CNT_W'(v);
      tick(1);
      per_wr = 1'b0;
   endtask

   task automatic do_arm();
      arm = 1'b1;
      tick(1);
      arm = 1'b0;
   endtask

   // drives a two-cycle-high trigger; c is the cycle of the rising drive
   task automatic fire(output int c);
      c = cyc;
      trig_in = 1'b1;
      tick(2);
      trig_in = 1'b0;
      tick(1);
   endtask

   task automatic expect_pulse(input int c, input int d, input int n, input string req);
      exp_t e;
      e.rise_at = c + 3 + d;
      e.width   = n - d;
      e.req     = req;
      exp_q.push_back(e);
   endtask

   // monitor: measures each pulse and compares it with the scoreboard head
   int  mon_rise = 0;
   int  mon_w = 0;
   bit  mon_prev = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         mon_prev = 1'b0;
      end else begin
         if (pulse_out && !mon_prev) begin
            mon_rise = cyc;
            mon_w = 0;
         end
         if (pulse_out) mon_w++;
         if (!pulse_out && mon_prev) begin
            pulses_seen++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected pulse", mon_rise, -1);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(mon_rise == e.rise_at, {e.req, " start cycle"}, mon_rise, e.rise_at);
               chk(mon_w == e.width, {e.req, " width"}, mon_w, e.width);
            end
         end
         mon_prev = pulse_out;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", cyc, 0);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      int c;
      int seen;
      tick(3);
      chk(pulse_out == 1'b0, "R1 pulse in reset", pulse_out, 0);
      chk(busy == 1'b0, "R1 busy in reset", busy, 0);
      rst = 1'b0;
      tick(1);
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);

      // R8: reset period is zero; arming and triggering produce nothing
      delay_val = 8'd2;
      do_arm();
      chk(busy == 1'b0, "R8 busy with zero period", busy, 0);
      seen = pulses_seen;
      fire(c);
      tick(15);
      chk(pulses_seen == seen, "R8 no pulse with zero period", pulses_seen, seen);

      // R7: immediate write; then R2/R3 timing and R4 retrigger immunity
      wr_period(6);
      chk(busy == 1'b1, "R7 write takes effect at once, R11 busy", busy, 1);
      fire(c);
      expect_pulse(c, 2, 6, "R2 R3");
      fire(c);   // edge during the pulse, R4
      fire(c);
      tick(15);
      chk(busy == 1'b0, "R11 busy after pulse", busy, 0);
      seen = pulses_seen;
      fire(c);
      tick(15);
      chk(pulses_seen == seen, "R5 trigger ignored after pulse", pulses_seen, seen);

      // R10: arm in the cycle the edge is detected
      c = cyc;
      trig_in = 1'b1;
      tick(2);
      arm = 1'b1;
      tick(1);
      arm = 1'b0;
      trig_in = 1'b0;
      expect_pulse(c, 2, 6, "R10");
      tick(20);

      // R3: delay not below period -> no high phase, counter still runs
      delay_val = 8'd6;
      do_arm();
      seen = pulses_seen;
      fire(c);
      chk(busy == 1'b1, "R3 counter runs when D>=N", busy, 1);
      tick(15);
      chk(pulses_seen == seen, "R3 no pulse when D>=N", pulses_seen, seen);
      chk(busy == 1'b0, "R3 idle after silent run", busy, 0);

      // R9: self-disable through a zero in the shadow
      shadow_en = 1'b1;
      delay_val = 8'd3;
      wr_period(8);
      do_arm();
      wr_period(0);
      fire(c);
      expect_pulse(c, 3, 8, "R9 last pulse");
      tick(20);
      chk(busy == 1'b0, "R9 disabled after pulse", busy, 0);
      do_arm();
      chk(busy == 1'b0, "R9 arm alone keeps zero period", busy, 0);
      seen = pulses_seen;
      fire(c);
      tick(15);
      chk(pulses_seen == seen, "R9 no pulse after self-disable", pulses_seen, seen);
      wr_period(5);
      do_arm();
      chk(busy == 1'b1, "R9 re-armed", busy, 1);
      fire(c);
      expect_pulse(c, 3, 5, "R9 re-arm pulse");
      tick(20);

      // R6: write during a running pulse is deferred; R5 arm during pulse ignored
      do_arm();
      c = cyc;
      trig_in = 1'b1;
      tick(2);
      trig_in = 1'b0;
      per_wr = 1'b1;
      per_data = 8'd9;
      tick(1);
      per_wr = 1'b0;
      arm = 1'b1;
      tick(1);
      arm = 1'b0;
      expect_pulse(c, 3, 5, "R6 old period kept");
      tick(20);
      chk(busy == 1'b0, "R5 arm during pulse ignored", busy, 0);
      do_arm();
      fire(c);
      expect_pulse(c, 3, 9, "R6 new period after update");
      tick(20);

      // R7: no shadow; arm does not reload, write is immediate
      shadow_en = 1'b0;
      do_arm();
      wr_period(4);
      fire(c);
      expect_pulse(c, 3, 4, "R7 immediate period");
      tick(20);

      chk(exp_q.size() == 0, "R2 all expected pulses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule